// File: doc/BRIEF.md
# SDRAM Full-Page Burst Read Sequencer

This block sits on the controller side of a single-data-rate SDRAM and reads a run of words from one row, using the device's full-page burst mode. A request carries a bank, a row, a start column and a word count. The block opens the row with ACTIVE and waits the row-to-column delay. It then issues one READ at the start column. Every word the device returns is captured after the CAS latency and presented on a valid/data stream, together with the column it came from.

A full-page burst never ends by itself. It steps through the 256 columns of the row, wraps past the last column and keeps going. The sequencer therefore counts the words and sends BURST TERMINATE in the cycle that stops the device exactly after the requested count. The row is left open and no precharge is issued. The surrounding controller owns precharge, refresh and mode setup, and presents requests only to a bank that is ready to be activated.

Top module: `sdram_burst_rd`

## Requirements
- R1: After reset, `req_ready_o` is 1, `rd_valid_o` is 0 and the command pins show NOP (`sd_cs_n_o`=0, {RAS#,CAS#,WE#}=111).
- R2: An accepted request (`req_valid_i` with `req_ready_o` high and nonzero length) puts ACTIVE ({RAS#,CAS#,WE#}=011) on the pins in the next cycle, with `sd_ba_o` equal to the bank and `sd_addr_o` equal to the row. `req_ready_o` stays low until the sequence ends.
- R3: READ (101) appears exactly T_RCD cycles after ACTIVE, with NOP in between. During READ, the start column is on `sd_addr_o[COL_W-1:0]` and all other address bits are 0, which keeps the auto-precharge bit A10 low.
- R4: The first word is captured at the CAS_LAT-th clock edge after the edge that samples READ. It is shown with `rd_valid_o` high in the cycle that follows that edge.
- R5: For a length N, exactly N words are presented, with `rd_valid_o` high on N consecutive cycles.
- R6: `rd_col_o` gives the column of each word: the start column plus the word index, modulo 2^COL_W (256), so the columns wrap within the row.
- R7: BURST TERMINATE (110) appears exactly N cycles after READ and is followed by NOP. No other command is issued before the next request.
- R8: A request with length 0, or a request presented while `req_ready_o` is low, is ignored: no ACTIVE is issued for it.
- R9: Lengths above 256 are accepted. The columns keep wrapping, so words of the row are returned again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_bank_i | input | BANK_W | Bank of the request |
| req_row_i | input | ROW_W | Row to open |
| req_col_i | input | COL_W | Start column |
| req_len_i | input | LEN_W | Number of words, 0 is ignored |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | BANK_W | Bank address |
| sd_addr_o | output | ADDR_W | Row or column address |
| sd_dq_i | input | DATA_W | Read data from the device |
| rd_valid_o | output | 1 | Read word valid |
| rd_data_o | output | DATA_W | Read word |
| rd_col_o | output | COL_W | Column of the read word |

## Verification
The bench keeps the default parameters: a 256-column row, T_RCD of 2 and CAS_LAT of 2. A behavioural device model in the bench produces a word that encodes bank, row and column, and keeps bursting until it sees the terminate command. With only 256 columns, a full-row read starting mid-row and a 300-word read both finish in a few hundred cycles, so wrap-around and repeated words are reached directly. The short row-to-column delay also puts single-word reads, where terminate follows READ at once, in the same short run.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
  // {RAS#, CAS#, WE#}, CS# held low
  typedef enum logic [2:0] {
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_RUN,
    ST_TERM
  } seq_st_e;
endpackage

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  parameter int LEN_W  = 9,
  parameter int T_RCD  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output sd_cmd_e           cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int WAIT_W = (T_RCD > 1) ? $clog2(T_RCD) : 1;

  seq_st_e           st_q;
  sd_cmd_e           cmd_q;
  logic [BANK_W-1:0] ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WAIT_W-1:0] wait_q;
  logic [LEN_W-1:0]  left_q;
  logic [COL_W-1:0]  col_q;
  logic [ADDR_W-1:0] rd_addr;
  logic              accept;

  assign accept = (st_q == ST_IDLE) && req_valid_i && (req_len_i != '0);

  always_comb begin
    rd_addr = '0;
    rd_addr[COL_W-1:0] = col_q;
    rd_addr[AP_BIT] = 1'b0;  // no auto-precharge
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      wait_q <= '0;
      left_q <= '0;
      col_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          cmd_q  <= CMD_NOP;
          addr_q <= '0;
          if (accept) begin
            cmd_q  <= CMD_ACT;
            ba_q   <= req_bank_i;
            addr_q <= ADDR_W'(req_row_i);
            wait_q <= WAIT_W'(T_RCD - 1);
            left_q <= req_len_i;
            col_q  <= req_col_i;
            st_q   <= ST_OPEN;
          end
        end
        ST_OPEN: begin
          if (wait_q == '0) begin
            cmd_q  <= CMD_RD;
            addr_q <= rd_addr;
            st_q   <= ST_RUN;
          end else begin
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            wait_q <= wait_q - 1'b1;
          end
        end
        ST_RUN: begin
          // first RUN edge is the one that samples READ
          addr_q <= '0;
          if (left_q == LEN_W'(1)) begin
            cmd_q <= CMD_BST;
            st_q  <= ST_TERM;
          end else begin
            cmd_q  <= CMD_NOP;
            left_q <= left_q - 1'b1;
          end
        end
        ST_TERM: begin
          cmd_q <= CMD_NOP;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign cmd_o       = cmd_q;
  assign ba_o        = ba_q;
  assign addr_o      = addr_q;
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture
  import sdram_rd_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int DATA_W  = 32,
  parameter int CAS_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sd_cmd_e           cmd_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [COL_W-1:0]  col_o
);
  // tracks the device burst from the command bus itself
  logic             live_q, live_now;
  logic [COL_W-1:0] col_run_q, cur_col;
  logic             v_pipe [CAS_LAT];
  logic [COL_W-1:0] c_pipe [CAS_LAT];

  assign live_now = (cmd_i == CMD_RD) || (live_q && (cmd_i != CMD_BST));
  assign cur_col  = (cmd_i == CMD_RD) ? col_i : col_run_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q    <= 1'b0;
      col_run_q <= '0;
      v_pipe[0] <= 1'b0;
      c_pipe[0] <= '0;
    end else begin
      live_q    <= live_now;
      v_pipe[0] <= live_now;
      if (live_now) begin
        col_run_q <= cur_col;
        c_pipe[0] <= cur_col;
      end
    end
  end

  for (genvar i = 1; i < CAS_LAT; i++) begin : g_lat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_pipe[i] <= 1'b0;
        c_pipe[i] <= '0;
      end else begin
        v_pipe[i] <= v_pipe[i-1];
        c_pipe[i] <= c_pipe[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      col_o   <= '0;
    end else begin
      valid_o <= v_pipe[CAS_LAT-1];
      if (v_pipe[CAS_LAT-1]) begin
        data_o <= dq_i;
        col_o  <= c_pipe[CAS_LAT-1];
      end
    end
  end
endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd
  import sdram_rd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int ADDR_W  = 12,
  parameter int AP_BIT  = 10,
  parameter int LEN_W   = COL_W + 1,
  parameter int T_RCD   = 2,
  parameter int CAS_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              sd_cs_n_o,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic [BANK_W-1:0] sd_ba_o,
  output logic [ADDR_W-1:0] sd_addr_o,
  input  logic [DATA_W-1:0] sd_dq_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [COL_W-1:0]  rd_col_o
);
  sd_cmd_e cmd;

  sdram_rd_seq #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .AP_BIT(AP_BIT), .LEN_W(LEN_W), .T_RCD(T_RCD)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_bank_i (req_bank_i),
    .req_row_i  (req_row_i),
    .req_col_i  (req_col_i),
    .req_len_i  (req_len_i),
    .cmd_o      (cmd),
    .ba_o       (sd_ba_o),
    .addr_o     (sd_addr_o)
  );

  sdram_rd_capture #(
    .COL_W(COL_W), .DATA_W(DATA_W), .CAS_LAT(CAS_LAT)
  ) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .col_i  (sd_addr_o[COL_W-1:0]),
    .dq_i   (sd_dq_i),
    .valid_o(rd_valid_o),
    .data_o (rd_data_o),
    .col_o  (rd_col_o)
  );

  assign sd_cs_n_o = 1'b0;
  assign {sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd;
endmodule

// File: rtl/sdram_rd_chk.sv
module sdram_rd_chk
  import sdram_rd_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  parameter int T_RCD  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              sd_ras_n_o,
  input logic              sd_cas_n_o,
  input logic              sd_we_n_o,
  input logic [ADDR_W-1:0] sd_addr_o,
  input logic              rd_valid_o,
  input logic [COL_W-1:0]  rd_col_o
);
  logic [2:0] cmd;
  logic [7:0] since_act;

  assign cmd = {sd_ras_n_o, sd_cas_n_o, sd_we_n_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_act <= 8'hFF;
    else if (cmd == CMD_ACT) since_act <= 8'd1;
    else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
  end

  // R2
  act_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_ACT) |-> $past(req_valid_i && req_ready_o));

  // R3
  rcd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_RD) |-> (since_act == 8'(T_RCD)));

  // R3
  no_autopre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_RD) |-> !sd_addr_o[AP_BIT]);

  // R7
  bst_then_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_BST) |=> (cmd == CMD_NOP));

  // R6
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(rd_valid_o)) |-> (rd_col_o == COL_W'($past(rd_col_o) + 1'b1)));

  // R2
  busy_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != CMD_NOP) |-> !req_ready_o);
endmodule

bind sdram_burst_rd sdram_rd_chk #(
  .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .T_RCD(T_RCD)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .sd_ras_n_o (sd_ras_n_o),
  .sd_cas_n_o (sd_cas_n_o),
  .sd_we_n_o  (sd_we_n_o),
  .sd_addr_o  (sd_addr_o),
  .rd_valid_o (rd_valid_o),
  .rd_col_o   (rd_col_o)
);

// File: tb/tb_sdram_burst_rd.sv
`timescale 1ns/1ps
module tb_sdram_burst_rd;
  localparam int DW = 32, BW = 2, RW = 12, CW = 8, AW = 12, LW = 9;
  localparam int TRCD = 2, CL = 2;
  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_BST = 3'b110, C_NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [BW-1:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic [LW-1:0] req_len = '0;
  logic cs_n, ras_n, cas_n, we_n;
  logic [BW-1:0] sd_ba;
  logic [AW-1:0] sd_addr;
  logic [DW-1:0] sd_dq = 32'hBAD0_BAD0;
  logic rd_valid;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] rd_col;

  always #2.5 clk = ~clk;

  sdram_burst_rd dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col), .req_len_i(req_len),
    .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n), .sd_cas_n_o(cas_n), .sd_we_n_o(we_n),
    .sd_ba_o(sd_ba), .sd_addr_o(sd_addr), .sd_dq_i(sd_dq),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_col_o(rd_col)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input logic [BW-1:0] b, input logic [RW-1:0] r,
                                        input logic [CW-1:0] c);
    return {4'hC, 2'b00, b, 4'h0, r, c};
  endfunction

  // device model: bursts until terminate
  logic [BW-1:0] m_ba = '0;
  logic [RW-1:0] m_row = '0;
  logic m_live = 1'b0;
  logic [CW-1:0] m_col = '0;
  logic h_v [CL];
  logic [CW-1:0] h_c [CL];
  initial for (int i = 0; i < CL; i++) begin h_v[i] = 1'b0; h_c[i] = '0; end

  always @(posedge clk) begin
    if ({ras_n, cas_n, we_n} == C_ACT) begin m_ba <= sd_ba; m_row <= sd_addr[RW-1:0]; end
    if ({ras_n, cas_n, we_n} == C_RD) begin m_live = 1'b1; m_col = sd_addr[CW-1:0]; end
    else if ({ras_n, cas_n, we_n} == C_BST) m_live = 1'b0;
    else if (m_live) m_col = m_col + 1'b1;
    for (int i = CL - 1; i > 0; i--) begin h_v[i] = h_v[i-1]; h_c[i] = h_c[i-1]; end
    h_v[0] = m_live; h_c[0] = m_col;
    sd_dq <= h_v[CL-1] ? pat(m_ba, m_row, h_c[CL-1]) : 32'hBAD0_BAD0;
  end

  // scoreboard state
  logic [DW-1:0] exp_d[$];
  logic [CW-1:0] exp_c[$];
  string tag = "R5";
  int cyc = 0, act_cnt = 0, act_cyc = 0, rd_cyc = 0, vcount = 0;
  int exp_len = 0;
  logic [BW-1:0] e_ba;
  logic [RW-1:0] e_row;
  logic [CW-1:0] e_col;
  bit first_seen = 0, prev_bst = 0, prev_v = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // command and data monitor
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] c;
      c = {ras_n, cas_n, we_n};
      if (prev_bst) chk(c == C_NOP, "R7", "cmd after terminate", c, C_NOP);
      prev_bst = (c == C_BST);
      if (c == C_ACT) begin
        act_cnt++;
        act_cyc = cyc;
        chk(sd_ba == e_ba && sd_addr == AW'(e_row), "R2", "activate bank/row",
            {sd_ba, sd_addr}, {e_ba, AW'(e_row)});
      end
      if (c == C_RD) begin
        rd_cyc = cyc;
        chk(cyc - act_cyc == TRCD, "R3", "activate-to-read cycles", cyc - act_cyc, TRCD);
        chk(sd_addr == AW'(e_col), "R3", "read address", sd_addr, AW'(e_col));
      end
      if (c == C_BST)
        chk(cyc - rd_cyc == exp_len, "R7", "read-to-terminate cycles", cyc - rd_cyc, exp_len);
      if (rd_valid) begin
        if (!first_seen) begin
          chk(cyc == rd_cyc + CL + 1, "R4", "first word cycle", cyc, rd_cyc + CL + 1);
          first_seen = 1;
        end else if (!prev_v) chk(0, "R5", "gap in valid run", 0, 1);
        vcount++;
        if (exp_d.size() == 0) chk(0, "R5", "extra word", rd_data, 0);
        else begin
          logic [DW-1:0] d;
          logic [CW-1:0] cc;
          d = exp_d.pop_front();
          cc = exp_c.pop_front();
          chk(rd_data == d, tag, "data", rd_data, d);
          chk(rd_col == cc, tag, "column", rd_col, cc);
        end
      end
      prev_v = rd_valid;
    end
  end

  task automatic do_req(input logic [BW-1:0] b, input logic [RW-1:0] r,
                        input logic [CW-1:0] c, input int n, input string t);
    while (!req_ready) @(negedge clk);
    e_ba = b; e_row = r; e_col = c; exp_len = n; tag = t;
    vcount = 0; first_seen = 0;
    for (int i = 0; i < n; i++) begin
      logic [CW-1:0] cc;
      cc = CW'(int'(c) + i);
      exp_c.push_back(cc);
      exp_d.push_back(pat(b, r, cc));
    end
    req_bank = b; req_row = r; req_col = c; req_len = LW'(n); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!req_ready) @(negedge clk);
    repeat (CL + 3) @(negedge clk);
    chk(vcount == exp_len, "R5", "word count", vcount, exp_len);
    chk(exp_d.size() == 0, "R5", "words left in scoreboard", exp_d.size(), 0);
  endtask

  initial begin
    int a0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "cmd in reset",
        {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(rd_valid == 1'b0, "R1", "valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_req(2'd1, 12'h0A5, 8'd0, 1, "R5");
    wait_done();
    do_req(2'd2, 12'h3C3, 8'd10, 4, "R5");
    wait_done();
    do_req(2'd3, 12'hFFF, 8'd252, 8, "R6");
    wait_done();
    do_req(2'd0, 12'h123, 8'd100, 256, "R6");
    wait_done();
    do_req(2'd1, 12'h456, 8'd5, 300, "R9");
    wait_done();

    // R8: zero length ignored
    a0 = act_cnt;
    req_bank = 2'd2; req_row = 12'h777; req_col = 8'd3; req_len = '0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk({ras_n, cas_n, we_n} == C_NOP && req_ready, "R8", "zero-length request",
          {req_ready, ras_n, cas_n, we_n}, {1'b1, C_NOP});
    end
    chk(act_cnt == a0, "R8", "activate count after zero length", act_cnt, a0);

    // R8: request while busy ignored
    a0 = act_cnt;
    do_req(2'd3, 12'h0F0, 8'd200, 12, "R5");
    req_bank = 2'd0; req_row = 12'h999; req_col = 8'd1; req_len = 9'd5; req_valid = 1'b1;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    chk(act_cnt == a0 + 1, "R8", "activate count with busy request", act_cnt, a0 + 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule